// File: doc/BRIEF.md
# Quad Fabric Frame Receiver

This block takes in frames on four independent inbound switch-fabric lanes. Each lane has a 32-bit data bus, a start-of-frame strobe and a parity bit. All of these are sampled on every rising clock edge. A frame is eighteen words long:

- Word 0 is a header, and it opens the frame when the strobe is high.
- Words 1 to 16 carry a 64-byte payload.
- Word 17 is a vertical parity word.

The receiver checks odd parity on every word that belongs to a frame. It folds the header and the payload into a running column-wise XOR and compares that XOR with the final word. It passes each payload word downstream one cycle after it arrives, with a valid strobe and a last-word marker. The header and the vertical parity word go no further than the receiver.

Errors collect in one status byte that is shared by the four lanes. Each bit of the byte is sticky and clears when a read strobe is applied. An error that arrives in the same cycle as the read survives the read. An error that keeps recurring sets its bit again after the read.

Each lane runs its own three-state machine:

- **ST_HUNT** waits for a frame and ignores data and parity.
- **ST_PAYLOAD** takes words 1 to 16.
- **ST_VPAR** expects the trailer word.

The transitions are:

- HUNT_TO_PAYLOAD: a strobe arrives while hunting.
- PAYLOAD_RESTART: a strobe arrives while taking payload.
- PAYLOAD_TO_VPAR: payload word 16 arrives without a strobe.
- VPAR_TO_HUNT: the trailer arrives without a strobe.
- VPAR_RESTART: a strobe arrives in place of the trailer.

Top module: `frx_quad_rx`

## Requirements
- R1: A word sampled with the start-of-frame strobe high is a header. The receiver takes it as word 0 of a new frame and never forwards it.
- R2: Payload words 1 to 16 appear on the lane's data output one cycle after they are sampled, with valid high. The last-word marker is high only with word 16.
- R3: Parity is odd. A frame word is any word sampled with the strobe high or while a frame is open, the header included. A frame word whose 32 data bits plus its parity bit hold an even number of ones sets that lane's horizontal bit in the status byte at the sampling edge.
- R4: A word sampled while the lane is hunting without the strobe is ignored. Its parity has no effect, and nothing is forwarded.
- R5: Word 17 of a complete frame must equal the XOR of words 0 to 16. A mismatch sets that lane's vertical bit.
- R6: A strobe that arrives before word 17 abandons the open frame. The new word becomes word 0 of a fresh frame, and the abandoned frame gets no vertical check.
- R7: Status bit c (c = 0 to 3) holds lane c's horizontal error. Status bit 4+c holds lane c's vertical error.
- R8: A status bit that is set stays set until a read strobe is sampled.
- R9: A read clears every bit that has no new error in the same cycle. An error that continues after the read sets its bit again.
- R10: An error sampled in the same cycle as a read leaves its bit set after that read.
- R11: After reset the status byte is zero, and no lane forwards a word until a frame arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | NCH | Start-of-frame strobe, one per lane |
| par_i | input | NCH | Odd parity bit of each lane's word |
| data_i | input | NCH*DW | Lane words, lane c at bits c*DW upward |
| pl_valid_o | output | NCH | Payload word valid, per lane |
| pl_last_o | output | NCH | Marks payload word 16, per lane |
| pl_data_o | output | NCH*DW | Forwarded payload words |
| stat_rd_i | input | 1 | Read strobe for the status byte |
| stat_o | output | 2*NCH | Sticky error byte: horizontal low, vertical high |

## Verification
The hardest case to reach is a frame abandoned at word 17, where a new header stands in the trailer's slot. A faulty receiver would compare that header with its accumulator and raise a false vertical error. The stimulus sends 17-word and 10-word frames immediately followed by full frames, with no gap. A second hard case is a read that lands in the same cycle as a parity error inside a frame. To reach it, the frame driver can raise the read strobe at any chosen word index and compares the status byte at every word.

// File: rtl/frx_pkg.sv
package frx_pkg;

    // Per-lane receive sequencing
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_PAYLOAD = 2'd1,
        ST_VPAR    = 2'd2
    } rx_state_e;

    localparam int unsigned DEF_DW            = 32;
    localparam int unsigned DEF_PAYLOAD_WORDS = 16;
    localparam int unsigned DEF_NCH           = 4;

endpackage

// File: rtl/frx_vacc.sv
module frx_vacc #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          fold_i,
    input  logic [DW-1:0] word_i,
    output logic [DW-1:0] acc_o
);

    logic [DW-1:0] acc_q;

    // Column-wise parity: the header seeds it, payload words fold in
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load_i) begin
            acc_q <= word_i;
        end else if (fold_i) begin
            acc_q <= acc_q ^ word_i;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/frx_lane.sv
module frx_lane
    import frx_pkg::*;
#(
    parameter int unsigned DW            = 32,
    parameter int unsigned PAYLOAD_WORDS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sof_i,
    input  logic          par_i,
    input  logic [DW-1:0] data_i,
    output logic          pl_valid_o,
    output logic          pl_last_o,
    output logic [DW-1:0] pl_data_o,
    output logic          hperr_o,
    output logic          vperr_o
);

    localparam int unsigned     CW       = $clog2(PAYLOAD_WORDS + 1);
    localparam logic [CW-1:0]   LAST_IDX = CW'(PAYLOAD_WORDS);
    localparam logic [CW-1:0]   FIRST_PL = CW'(1);

    rx_state_e     state_q, state_d;
    logic [CW-1:0] idx_q;
    logic [DW-1:0] vacc;
    logic          in_frame;
    logic          take_pl;
    logic          at_last;

    assign in_frame = sof_i || (state_q != ST_HUNT);
    assign take_pl  = (state_q == ST_PAYLOAD) && !sof_i;
    assign at_last  = (idx_q == LAST_IDX);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (sof_i) state_d = ST_PAYLOAD;          // HUNT_TO_PAYLOAD
            end
            ST_PAYLOAD: begin
                if (sof_i)        state_d = ST_PAYLOAD;   // PAYLOAD_RESTART
                else if (at_last) state_d = ST_VPAR;      // PAYLOAD_TO_VPAR
            end
            ST_VPAR: begin
                if (sof_i) state_d = ST_PAYLOAD;          // VPAR_RESTART
                else       state_d = ST_HUNT;             // VPAR_TO_HUNT
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Index of the next expected word within the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (sof_i) begin
            idx_q <= FIRST_PL;
        end else if (take_pl) begin
            idx_q <= idx_q + CW'(1);
        end
    end

    frx_vacc #(.DW(DW)) u_vacc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sof_i),
        .fold_i (take_pl),
        .word_i (data_i),
        .acc_o  (vacc)
    );

    // Error events, taken by the status register at this edge
    assign hperr_o = in_frame && !(^{data_i, par_i});
    assign vperr_o = (state_q == ST_VPAR) && !sof_i && (vacc != data_i);

    // Registered downstream outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pl_valid_o <= 1'b0;
            pl_last_o  <= 1'b0;
            pl_data_o  <= '0;
        end else begin
            pl_valid_o <= take_pl;
            pl_last_o  <= take_pl && at_last;
            pl_data_o  <= data_i;
        end
    end

endmodule

// File: rtl/frx_status.sv
module frx_status #(
    parameter int unsigned NCH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   hp_evt_i,
    input  logic [NCH-1:0]   vp_evt_i,
    input  logic             rd_i,
    output logic [2*NCH-1:0] status_o
);

    localparam int unsigned SW = 2 * NCH;

    logic [SW-1:0] evt;
    logic [SW-1:0] bits_q;

    assign evt = {vp_evt_i, hp_evt_i};

    // One sticky bit per error source; a new event wins over a read
    for (genvar b = 0; b < SW; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)      bits_q[b] <= 1'b0;
            else if (evt[b]) bits_q[b] <= 1'b1;
            else if (rd_i)   bits_q[b] <= 1'b0;
        end
    end

    assign status_o = bits_q;

endmodule

// File: rtl/frx_quad_rx.sv
module frx_quad_rx
    import frx_pkg::*;
#(
    parameter int unsigned NCH           = DEF_NCH,
    parameter int unsigned DW            = DEF_DW,
    parameter int unsigned PAYLOAD_WORDS = DEF_PAYLOAD_WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     sof_i,
    input  logic [NCH-1:0]     par_i,
    input  logic [NCH*DW-1:0]  data_i,
    output logic [NCH-1:0]     pl_valid_o,
    output logic [NCH-1:0]     pl_last_o,
    output logic [NCH*DW-1:0]  pl_data_o,
    input  logic               stat_rd_i,
    output logic [2*NCH-1:0]   stat_o
);

    logic [NCH-1:0] hp_evt;
    logic [NCH-1:0] vp_evt;

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        frx_lane #(
            .DW            (DW),
            .PAYLOAD_WORDS (PAYLOAD_WORDS)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .sof_i      (sof_i[c]),
            .par_i      (par_i[c]),
            .data_i     (data_i[c*DW +: DW]),
            .pl_valid_o (pl_valid_o[c]),
            .pl_last_o  (pl_last_o[c]),
            .pl_data_o  (pl_data_o[c*DW +: DW]),
            .hperr_o    (hp_evt[c]),
            .vperr_o    (vp_evt[c])
        );
    end

    frx_status #(.NCH(NCH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hp_evt_i (hp_evt),
        .vp_evt_i (vp_evt),
        .rd_i     (stat_rd_i),
        .status_o (stat_o)
    );

endmodule

// File: rtl/frx_quad_rx_chk.sv
module frx_quad_rx_chk #(
    parameter int unsigned NCH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   sof_i,
    input logic [NCH-1:0]   pl_valid_o,
    input logic [NCH-1:0]   pl_last_o,
    input logic             stat_rd_i,
    input logic [2*NCH-1:0] stat_o,
    input logic [NCH-1:0]   hp_evt,
    input logic [NCH-1:0]   vp_evt
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R1: a header is never forwarded
        p_hdr_hidden_r1: assert property (@(posedge clk) disable iff (!rst_n)
            sof_i[c] |=> !pl_valid_o[c]);

        // R2: the last marker only rides on a valid word
        p_last_has_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
            pl_last_o[c] |-> pl_valid_o[c]);

        // R3: a horizontal event lands in bit c
        p_hbit_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
            hp_evt[c] |=> stat_o[c]);

        // R5: a vertical event lands in bit NCH+c, never on a header
        p_vbit_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
            vp_evt[c] |=> stat_o[NCH+c]);

        p_vchk_not_on_sof_r6: assert property (@(posedge clk) disable iff (!rst_n)
            vp_evt[c] |-> !sof_i[c]);
    end

    // R8: without a read no set bit drops
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

    // R9: a read with no concurrent event empties the byte
    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && (hp_evt == '0) && (vp_evt == '0)) |=> (stat_o == '0));

    // R10: events coinciding with a read survive it
    p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_i |=> ((stat_o & $past({vp_evt, hp_evt})) == $past({vp_evt, hp_evt})));

endmodule

bind frx_quad_rx frx_quad_rx_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof_i      (sof_i),
    .pl_valid_o (pl_valid_o),
    .pl_last_o  (pl_last_o),
    .stat_rd_i  (stat_rd_i),
    .stat_o     (stat_o),
    .hp_evt     (hp_evt),
    .vp_evt     (vp_evt)
);

// File: tb/frx_quad_rx_bench.sv
module frx_quad_rx_bench;

    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int PW  = 16;
    localparam int FW  = PW + 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NCH-1:0]     sof_i = '0;
    logic [NCH-1:0]     par_i = '0;
    logic [NCH*DW-1:0]  data_i = '0;
    logic [NCH-1:0]     pl_valid_o;
    logic [NCH-1:0]     pl_last_o;
    logic [NCH*DW-1:0]  pl_data_o;
    logic               stat_rd_i = 1'b0;
    logic [2*NCH-1:0]   stat_o;

    always #4 clk = ~clk;

    frx_quad_rx u_frx_quad_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_i      (sof_i),
        .par_i      (par_i),
        .data_i     (data_i),
        .pl_valid_o (pl_valid_o),
        .pl_last_o  (pl_last_o),
        .pl_data_o  (pl_data_o),
        .stat_rd_i  (stat_rd_i),
        .stat_o     (stat_o)
    );

    typedef struct {
        int          ch;
        logic [31:0] data;
        logic        last;
    } item_t;

    item_t            exp_q[$];
    int               n_chk = 0;
    int               n_fail = 0;
    logic [2*NCH-1:0] exp_stat = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] word_of(input int ch, input int seed, input int i);
        return (32'(ch) << 28) ^ (32'(seed) << 16) ^ 32'(i * 37 + 5) ^ 32'h0F0F_0A00;
    endfunction

    // Monitor: pop and compare every forwarded word (R1, R2)
    always @(negedge clk) begin
        item_t it;
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                if (pl_valid_o[c]) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R1", "unexpected forwarded word", 64'(c), 64'hFF);
                    end else begin
                        it = exp_q.pop_front();
                        chk(it.ch == c, "R2", "lane of word", 64'(c), 64'(it.ch));
                        chk(pl_data_o[c*DW +: DW] == it.data, "R2", "payload data",
                            64'(pl_data_o[c*DW +: DW]), 64'(it.data));
                        chk(pl_last_o[c] == it.last, "R2", "last marker",
                            64'(pl_last_o[c]), 64'(it.last));
                    end
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            stat_rd_i = 1'b0;
            sof_i     = '0;
            par_i     = '0;     // data 0 with parity 0 is even: bad if checked (R4)
            data_i    = '0;
        end
    endtask

    // Driver: sends nw words of a frame; words hlo..hhi get bad parity,
    // vbad corrupts the trailer, rd_at raises the read strobe at that word.
    task automatic send_frame(input int ch, input int nw, input int hlo, input int hhi,
                              input bit vbad, input int rd_at, input int seed);
        logic [31:0] acc = '0;
        logic [31:0] w;
        bit          eh;
        bit          ev;
        for (int i = 0; i < nw; i++) begin
            @(negedge clk);
            stat_rd_i = 1'b0;
            chk(stat_o == exp_stat, "R8", "status during frame", 64'(stat_o), 64'(exp_stat));
            if (i == FW - 1) begin
                w = acc ^ (vbad ? 32'h0000_0100 : 32'h0);
            end else begin
                w   = word_of(ch, seed, i);
                acc = acc ^ w;
            end
            eh = (i >= hlo) && (i <= hhi);
            ev = (i == FW - 1) && vbad;
            data_i[ch*DW +: DW] = w;
            sof_i[ch] = (i == 0);
            par_i[ch] = ~(^w) ^ eh;
            if (i >= 1 && i <= PW) exp_q.push_back('{ch, w, (i == PW)});
            if (i == rd_at) stat_rd_i = 1'b1;
            @(posedge clk);
            if (i == rd_at) exp_stat = '0;
            if (eh) exp_stat[ch] = 1'b1;
            if (ev) exp_stat[NCH + ch] = 1'b1;
        end
    endtask

    task automatic read_status(input string req);
        @(negedge clk);
        sof_i = '0; par_i = '0; data_i = '0;
        chk(stat_o == exp_stat, req, "status before read", 64'(stat_o), 64'(exp_stat));
        stat_rd_i = 1'b1;
        @(posedge clk);
        exp_stat = '0;
        @(negedge clk);
        stat_rd_i = 1'b0;
        chk(stat_o == '0, "R9", "status after read", 64'(stat_o), 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R11", "watchdog expired", 64'h0, 64'h1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stat_o == '0, "R11", "status after reset", 64'(stat_o), 64'h0);
        chk(pl_valid_o == '0, "R11", "valid after reset", 64'(pl_valid_o), 64'h0);

        // Clean frame; surrounding idle words carry even parity (R4)
        idle(3);
        send_frame(0, FW, -1, -1, 1'b0, -1, 1);
        idle(4);
        read_status("R4");

        // Horizontal error on each lane lands in bit c (R3, R7)
        for (int c = 0; c < NCH; c++) begin
            send_frame(c, FW, 3, 3, 1'b0, -1, 10 + c);
            idle(2);
            chk(stat_o == (8'h01 << c), "R7", "horizontal bit position",
                64'(stat_o), 64'(8'h01 << c));
            read_status("R3");
        end

        // Bad parity on the header itself (R3)
        send_frame(3, FW, 0, 0, 1'b0, -1, 20);
        idle(2);
        read_status("R3");

        // Vertical errors on lanes 2 and 1 (R5, R7)
        send_frame(2, FW, -1, -1, 1'b1, -1, 21);
        idle(2);
        chk(stat_o == 8'h40, "R7", "vertical bit lane 2", 64'(stat_o), 64'h40);
        read_status("R5");
        send_frame(1, FW, -1, -1, 1'b1, -1, 22);
        idle(2);
        read_status("R5");

        // Back-to-back full frames, second with good trailer (R5)
        send_frame(0, FW, -1, -1, 1'b0, -1, 23);
        send_frame(0, FW, -1, -1, 1'b0, -1, 24);
        idle(2);
        read_status("R5");

        // Aborts: a new header in the trailer slot and mid-payload (R6)
        send_frame(1, FW - 1, -1, -1, 1'b0, -1, 30);
        send_frame(1, FW, -1, -1, 1'b0, -1, 31);
        idle(2);
        chk(stat_o == 8'h00, "R6", "no vertical check on abort", 64'(stat_o), 64'h0);
        send_frame(2, 10, -1, -1, 1'b0, -1, 32);
        send_frame(2, FW, -1, -1, 1'b0, -1, 33);
        idle(2);
        read_status("R6");

        // Error in the same cycle as a read survives it (R10)
        send_frame(0, FW, 6, 6, 1'b0, 6, 40);
        idle(2);
        chk(stat_o == 8'h01, "R10", "event during read", 64'(stat_o), 64'h01);
        read_status("R10");

        // Read clears, a later error re-sets the bit (R9)
        send_frame(3, FW, 2, 2, 1'b0, 5, 41);
        send_frame(3, FW, 9, 12, 1'b0, 3, 42);
        idle(2);
        chk(stat_o == 8'h08, "R9", "bit re-asserts", 64'(stat_o), 64'h08);
        read_status("R9");

        // Sticky across long idle (R8)
        send_frame(1, FW, 4, 4, 1'b1, -1, 50);
        idle(20);
        chk(stat_o == 8'h22, "R8", "sticky over idle", 64'(stat_o), 64'h22);
        read_status("R8");

        idle(3);
        chk(exp_q.size() == 0, "R2", "words still expected", 64'(exp_q.size()), 64'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule